// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Selector with Acknowledge

This block is the per-processor back end of an interrupt distributor. The source side forwards interrupts to it as one-cycle raise strobes, one per source slot (64 by default, of which the first 48 would normally be wired to external lines). The block keeps the set of raised sources and picks the one with the highest 5-bit priority. The priority buses carry the field already cut from each source's configuration word. While a winner is known, the block drives the processor's interrupt line.

The processor takes an interrupt with an acknowledge read. The block answers one cycle later with the winning source's vector and removes that source from the raised set. If the source is edge-triggered, it also sends a one-cycle clear strobe back to the source side, so that the source's pending and in-service state can be dropped there. The winner's index is cached in a register. The cache is invalidated whenever the raised set changes and is refilled from a combinational priority tree. When the cache is invalid at the moment of an acknowledge, the tree's current result is used directly, so no acknowledge ever waits.

Top module: `cpu_irq_select`

## Requirements
- R1: After reset the raised set is empty, and `irq_o`, `ack_valid_o` and every bit of `clr_edge_o` are 0.
- R2: A raise strobe on bit k makes source k a member of the raised set. Starting from an empty set, `irq_o` is 0 after the first clock edge that samples the strobe and 1 after the next edge.
- R3: The winner is the raised source whose priority field `prio_i[k*PRIO_W +: PRIO_W]` is greatest. The acknowledge answer is that source's vector `vec_i[k*VEC_W +: VEC_W]`.
- R4: When several raised sources share the top priority, the one with the lowest index wins. A source displaces the current candidate only if its priority is strictly greater.
- R5: An acknowledge read sampled at a clock edge gives `ack_valid_o` = 1 and the answer on `ack_vec_o` for the following cycle. The same edge removes the winner from the raised set.
- R6: An acknowledge with an empty raised set returns `SPUR_VEC` (default 8'hFF) and sends no clear strobe. `irq_o` is 0 whenever the raised set is empty.
- R7: For an acknowledged source k with `edge_i[k]` = 1, `clr_edge_o` carries only bit k for one cycle, in the cycle in which the answer appears. For a level source (`edge_i[k]` = 0), `clr_edge_o` stays all zero.
- R8: Any change of the raised set, and every acknowledge, invalidates the cached winner, so `irq_o` is 0 in the following cycle. The cache refills one cycle later. Back-to-back acknowledges are still each answered with the winner of the current raised set.
- R9: A raise strobe on a source in the same cycle as the acknowledge that removes it wins: the source stays in the raised set and is answered again by the next acknowledge.
- R10: A raised source with priority 0 is still a valid winner. The search starts below every priority, so such a source is answered with its vector, not with the spurious one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously upstream |
| raise_i | input | NUM_SRC | One-cycle raise strobe per source slot |
| prio_i | input | NUM_SRC*PRIO_W | Priority field of each source, slot k at bits k*PRIO_W upward |
| vec_i | input | NUM_SRC*VEC_W | Vector of each source, slot k at bits k*VEC_W upward |
| edge_i | input | NUM_SRC | 1 marks an edge-triggered source, 0 a level source |
| ack_rd_i | input | 1 | Acknowledge read strobe from the processor |
| irq_o | output | 1 | Interrupt request to the processor, high while a cached winner is valid |
| ack_valid_o | output | 1 | Acknowledge answer valid, one cycle after the read |
| ack_vec_o | output | VEC_W | Vector of the acknowledged source, or the spurious vector |
| clr_edge_o | output | NUM_SRC | One-hot clear strobe to the source side for acknowledged edge sources |

## Verification
The checker verifies these rules on every cycle: the interrupt line stays low with an empty set and drops after each change of the set; the cache refills once the set is quiet; each acknowledge is answered one cycle later and removes exactly one member; an empty acknowledge yields the spurious vector; and the clear strobe is never more than one-hot. Which source wins, and so the vector value and the clear-strobe bit, can only be shown by the bench. It sweeps every subset of raised sources in a small configuration, with varied priorities, ties and edge/level mixes, drains each subset with back-to-back acknowledges and compares the results with a strictly-greater scan it computes itself. The bench also drives the raise-during-acknowledge collision directly.

// File: rtl/cpu_irq_sel_pkg.sv
package cpu_irq_sel_pkg;

  // Width needed to hold an index in 0..n-1, at least one bit.
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_prio_scan.sv
// Combinational max-priority tree over the raised set.
// The left subtree always covers lower indices and wins ties.
module irq_prio_scan #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 5,
  parameter int unsigned IDX_W   = 6
) (
  input  logic [NUM_SRC-1:0]        member_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          idx_o
);

  localparam int unsigned LVL = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
  localparam int unsigned NP  = 1 << LVL;
  localparam int unsigned NN  = 2 * NP - 1;

  logic              nd_v [NN];
  logic [PRIO_W-1:0] nd_p [NN];
  logic [IDX_W-1:0]  nd_i [NN];

  for (genvar k = 0; k < NP; k++) begin : g_leaf
    if (k < NUM_SRC) begin : g_real
      assign nd_v[NP-1+k] = member_i[k];
      assign nd_p[NP-1+k] = prio_i[k*PRIO_W +: PRIO_W];
      assign nd_i[NP-1+k] = IDX_W'(k);
    end else begin : g_pad
      assign nd_v[NP-1+k] = 1'b0;
      assign nd_p[NP-1+k] = '0;
      assign nd_i[NP-1+k] = '0;
    end
  end

  for (genvar n = 0; n < NP - 1; n++) begin : g_node
    logic take_r;
    // Right side replaces left only on a strictly greater priority.
    assign take_r  = nd_v[2*n+2] &&
                     (!nd_v[2*n+1] || (nd_p[2*n+2] > nd_p[2*n+1]));
    assign nd_v[n] = nd_v[2*n+1] || nd_v[2*n+2];
    assign nd_p[n] = take_r ? nd_p[2*n+2] : nd_p[2*n+1];
    assign nd_i[n] = take_r ? nd_i[2*n+2] : nd_i[2*n+1];
  end

  assign hit_o = nd_v[0];
  assign idx_o = nd_i[0];

endmodule

// File: rtl/irq_raised_set.sv
// Raised-source bit vector: strobes set, one acknowledged slot clears.
module irq_raised_set #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raise_i,
  input  logic               clr_en_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] set_q,
  output logic               changed_o
);

  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] set_d;

  always_comb begin
    clr_mask = '0;
    if (clr_en_i) clr_mask = NUM_SRC'(1) << clr_idx_i;
    // A new raise outranks a same-cycle clear of that slot.
    set_d     = (set_q & ~clr_mask) | raise_i;
    changed_o = (set_d != set_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         set_q <= '0;
    else if (changed_o) set_q <= set_d;
  end

endmodule

// File: rtl/cpu_irq_select.sv
module cpu_irq_select
  import cpu_irq_sel_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned PRIO_W   = 5,
  parameter int unsigned VEC_W    = 8,
  parameter logic [VEC_W-1:0] SPUR_VEC = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        raise_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [NUM_SRC*VEC_W-1:0]  vec_i,
  input  logic [NUM_SRC-1:0]        edge_i,
  input  logic                      ack_rd_i,
  output logic                      irq_o,
  output logic                      ack_valid_o,
  output logic [VEC_W-1:0]          ack_vec_o,
  output logic [NUM_SRC-1:0]        clr_edge_o
);

  localparam int unsigned IDX_W = idx_width(NUM_SRC);

  logic [NUM_SRC-1:0] raised_q;
  logic               raised_chg;
  logic               scan_hit;
  logic [IDX_W-1:0]   scan_idx;

  // Cached winner; nxt_vld_q = 0 plays the role of "no index".
  logic               nxt_vld_q, nxt_vld_d;
  logic [IDX_W-1:0]   nxt_idx_q, nxt_idx_d;
  logic               nxt_en;

  logic               win_vld;
  logic [IDX_W-1:0]   win_idx;
  logic               take;

  logic               ackv_d;
  logic [VEC_W-1:0]   ackvec_d;
  logic [NUM_SRC-1:0] clr_d;
  logic               out_en;

  irq_raised_set #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_set (
    .clk      (clk),
    .rst_n    (rst_n),
    .raise_i  (raise_i),
    .clr_en_i (take),
    .clr_idx_i(win_idx),
    .set_q    (raised_q),
    .changed_o(raised_chg)
  );

  irq_prio_scan #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_scan (
    .member_i(raised_q),
    .prio_i  (prio_i),
    .hit_o   (scan_hit),
    .idx_o   (scan_idx)
  );

  // Winner used by an acknowledge: the cache if valid, else a fresh scan.
  always_comb begin
    win_vld = nxt_vld_q || scan_hit;
    win_idx = nxt_vld_q ? nxt_idx_q : scan_idx;
    take    = ack_rd_i && win_vld;
  end

  // Cache next state.
  always_comb begin
    nxt_vld_d = nxt_vld_q;
    nxt_idx_d = nxt_idx_q;
    nxt_en    = 1'b0;
    if (raised_chg || take) begin
      nxt_vld_d = 1'b0;
      nxt_en    = 1'b1;
    end else if (!nxt_vld_q) begin
      nxt_vld_d = scan_hit;
      nxt_idx_d = scan_idx;
      nxt_en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_vld_q <= 1'b0;
      nxt_idx_q <= '0;
    end else if (nxt_en) begin
      nxt_vld_q <= nxt_vld_d;
      nxt_idx_q <= nxt_idx_d;
    end
  end

  // Acknowledge answer and clear strobe, next state.
  always_comb begin
    ackv_d   = ack_rd_i;
    ackvec_d = take ? vec_i[win_idx*VEC_W +: VEC_W] : SPUR_VEC;
    clr_d    = '0;
    if (take && edge_i[win_idx]) clr_d = NUM_SRC'(1) << win_idx;
    out_en   = ack_rd_i || ack_valid_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_o <= 1'b0;
      ack_vec_o   <= '0;
      clr_edge_o  <= '0;
    end else if (out_en) begin
      ack_valid_o <= ackv_d;
      ack_vec_o   <= ackvec_d;
      clr_edge_o  <= clr_d;
    end
  end

  assign irq_o = nxt_vld_q;

endmodule

// File: rtl/cpu_irq_select_chk.sv
module cpu_irq_select_chk #(
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned VEC_W    = 8,
  parameter logic [VEC_W-1:0] SPUR_VEC = '1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] raise_i,
  input logic               ack_rd_i,
  input logic               irq_o,
  input logic               ack_valid_o,
  input logic [VEC_W-1:0]   ack_vec_o,
  input logic [NUM_SRC-1:0] clr_edge_o,
  input logic [NUM_SRC-1:0] raised_q
);

  p_empty_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raised_q == '0) |-> !irq_o);

  p_irq_has_member_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raised_q != '0));

  p_ack_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd_i |=> ack_valid_o);

  p_no_ack_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_rd_i |=> (!ack_valid_o && clr_edge_o == '0));

  p_ack_removes_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd_i && raised_q != '0 && raise_i == '0) |=>
      ($countones(raised_q) == $past($countones(raised_q)) - 1));

  p_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd_i && raised_q == '0) |=>
      (ack_vec_o == SPUR_VEC && clr_edge_o == '0));

  p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_edge_o));

  p_invalidate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (raised_q != $past(raised_q)) |-> !irq_o);

  p_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && raised_q != '0 && raise_i == '0 && !ack_rd_i) |=> irq_o);

endmodule

bind cpu_irq_select cpu_irq_select_chk #(
  .NUM_SRC (NUM_SRC),
  .VEC_W   (VEC_W),
  .SPUR_VEC(SPUR_VEC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .raise_i    (raise_i),
  .ack_rd_i   (ack_rd_i),
  .irq_o      (irq_o),
  .ack_valid_o(ack_valid_o),
  .ack_vec_o  (ack_vec_o),
  .clr_edge_o (clr_edge_o),
  .raised_q   (raised_q)
);

// File: tb/cpu_irq_select_bench.sv
`timescale 1ns/1ps
module cpu_irq_select_bench;

  localparam int N  = 8;
  localparam int PW = 5;
  localparam int VW = 8;
  localparam logic [VW-1:0] SPUR = 8'hFF;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    raise;
  logic [N*PW-1:0] prio;
  logic [N*VW-1:0] vec;
  logic [N-1:0]    edge_s;
  logic            ack_rd;
  logic            irq;
  logic            ack_valid;
  logic [VW-1:0]   ack_vec;
  logic [N-1:0]    clr_edge;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cpu_irq_select #(.NUM_SRC(N), .PRIO_W(PW), .VEC_W(VW), .SPUR_VEC(SPUR)) u_cpu_irq_select (
    .clk(clk), .rst_n(rst_n), .raise_i(raise), .prio_i(prio), .vec_i(vec),
    .edge_i(edge_s), .ack_rd_i(ack_rd), .irq_o(irq), .ack_valid_o(ack_valid),
    .ack_vec_o(ack_vec), .clr_edge_o(clr_edge)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Strictly-greater scan starting below every priority.
  function automatic int model_win(input logic [N-1:0] m);
    int best = -1;
    int bi   = -1;
    for (int k = 0; k < N; k++)
      if (m[k] && int'(prio[k*PW +: PW]) > best) begin
        best = int'(prio[k*PW +: PW]);
        bi   = k;
      end
    return bi;
  endfunction

  task automatic set_config(input int s);
    for (int k = 0; k < N; k++) begin
      prio[k*PW +: PW] = PW'(((k*5 + s*3) % 4) * ((s >= 128) ? 9 : 1));
      vec[k*VW +: VW]  = VW'(8'h20 + k*3 + (s % 2));
      edge_s[k]        = (((k + s) % 3) == 0);
    end
  endtask

  // Check one acknowledge answer against the model and update the mask.
  task automatic chk_ack(inout logic [N-1:0] m);
    int w = model_win(m);
    chk("R5 ack_valid", 64'(ack_valid), 64'(1));
    if (w >= 0) begin
      chk("R3 R4 R10 vector", 64'(ack_vec), 64'(vec[w*VW +: VW]));
      chk("R7 clear strobe", 64'(clr_edge),
          edge_s[w] ? 64'(1) << w : 64'(0));
      m[w] = 1'b0;
    end else begin
      chk("R6 spurious vector", 64'(ack_vec), 64'(SPUR));
      chk("R6 no clear", 64'(clr_edge), 64'(0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] m;
    rst_n  = 1'b0;
    raise  = '0;
    ack_rd = 1'b0;
    set_config(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    chk("R1 ack_valid", 64'(ack_valid), 0);
    chk("R1 clr", 64'(clr_edge), 0);

    // Sweep every subset of raised sources.
    for (int s = 0; s < 256; s++) begin
      set_config(s);
      raise = N'(s);
      @(negedge clk);
      raise = '0;
      chk("R2 R8 irq low after change", 64'(irq), 0);
      @(negedge clk);
      chk("R2 irq", 64'(irq), 64'(s != 0));
      m = N'(s);
      ack_rd = 1'b1;
      for (int j = 0; j <= $countones(s); j++) begin
        @(negedge clk);
        if (j == $countones(s)) ack_rd = 1'b0;
        chk_ack(m);
      end
      @(negedge clk);
      chk("R6 irq after drain", 64'(irq), 0);
      chk("R5 ack_valid drop", 64'(ack_valid), 0);
    end

    // R8: a further raise drops irq for one cycle, then refills.
    set_config(1);
    raise = 8'b0000_0100;
    @(negedge clk); raise = '0;
    @(negedge clk);
    chk("R8 irq valid", 64'(irq), 1);
    raise = 8'b0100_0000;
    @(negedge clk); raise = '0;
    chk("R8 irq invalidated", 64'(irq), 0);
    @(negedge clk);
    chk("R8 irq refilled", 64'(irq), 1);
    m = 8'b0100_0100;
    ack_rd = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      if (j == 2) ack_rd = 1'b0;
      chk_ack(m);
    end

    // R9: raise of the winner in the acknowledge cycle keeps it raised.
    for (int k = 0; k < N; k++) prio[k*PW +: PW] = '0;
    prio[3*PW +: PW] = 5'd4;
    prio[5*PW +: PW] = 5'd9;
    raise = 8'b0010_1000;
    @(negedge clk); raise = '0;
    @(negedge clk);
    ack_rd = 1'b1;
    raise  = 8'b0010_0000;
    @(negedge clk);
    ack_rd = 1'b0;
    raise  = '0;
    chk("R9 first answer", 64'(ack_vec), 64'(vec[5*VW +: VW]));
    @(negedge clk);
    @(negedge clk);
    chk("R9 irq kept", 64'(irq), 1);
    ack_rd = 1'b1;
    @(negedge clk);
    chk("R9 answered again", 64'(ack_vec), 64'(vec[5*VW +: VW]));
    @(negedge clk);
    chk("R4 next source", 64'(ack_vec), 64'(vec[3*VW +: VW]));
    @(negedge clk);
    ack_rd = 1'b0;
    chk("R6 spurious at end", 64'(ack_vec), 64'(SPUR));
    @(negedge clk);
    chk("R6 irq low", 64'(irq), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule